// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Read-Gated Flow Control

This block receives bytes over a clocked serial link in shift-register fashion. The shift clock comes from one of two sources. The block can generate it from the system clock through a divider and drive it on its own clock pin, or it can take it from an external master. Each frame has eight data bits, and the least significant bit arrives first. Bits enter a shift register. When the last bit is in, the finished byte is copied into a holding register that the processor can read. At that point a full flag rises and an interrupt pulse is issued.

The full flag stays set until the processor strobes a read. While it is set, reception is frozen. With the internal clock, no shift clock pulses are sent. With an external clock, incoming clock edges are discarded. A byte in the holding register can therefore never be overwritten, and the sending side is throttled by the receiver's own clock, or, with an external clock, by the flag.

Top module: `sio_rx_gate`

## Requirements
- R1: After reset, `rxFull` and `rxIrq` are 0, `rxData` is 0x00 and `sckOut` is 1.
- R2: With `clkSrcExt`=1 and `fallEdge`=0, a bit is taken from `serIn` on each rising edge of `extSck`. Bit 0 of the byte comes first and bit 7 last.
- R3: With `clkSrcExt`=1 and `fallEdge`=1, bits are taken on falling edges of `extSck` instead, in the same LSB-first order.
- R4: `rxFull` stays 0 until the eighth bit is taken. On that bit, the assembled byte appears on `rxData`, `rxFull` becomes 1, and `rxIrq` is high for exactly one clock cycle.
- R5: A `readStb` pulse while `rxFull` is 1 clears `rxFull` on the next cycle. It leaves `rxData` unchanged.
- R6: While `rxFull` is 1, `extSck` edges have no effect. The next byte is built only from edges that arrive after the flag clears, and `rxData` holds its value throughout.
- R7: With `clkSrcExt`=0 and reception enabled, `sckOut` idles at 1 and toggles every `HALF_DIV` system cycles. A bit is taken from `serIn` at each rising edge of `sckOut`, in LSB-first order.
- R8: With `clkSrcExt`=0, `sckOut` stays at 1 with no falling edges for as long as `rxFull` is 1. Clocking resumes after a read clears the flag.
- R9: While `rxEnable` is 0, no bits are taken and `rxData` and `rxFull` are not changed by serial traffic. Dropping `rxEnable` in the middle of a frame discards the partial bit count, so the next byte starts again from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Reception allowed when 1 |
| clkSrcExt | input | 1 | 1: shift clock taken from `extSck`; 0: generated on `sckOut` |
| fallEdge | input | 1 | External clock mode: 0 samples on rising edges, 1 on falling edges |
| readStb | input | 1 | One-cycle strobe marking a processor read of `rxData` |
| serIn | input | 1 | Serial data input (asynchronous) |
| extSck | input | 1 | External shift clock (asynchronous) |
| sckOut | output | 1 | Generated shift clock, idle high |
| rxData | output | DATA_W | Holding register with the last complete byte |
| rxFull | output | 1 | Byte waiting to be read |
| rxIrq | output | 1 | One-cycle pulse when `rxFull` rises |

## Verification
The hardest situation to reach from the ports is a clock edge arriving while the flag is still set. If such an edge slipped through, it would only show up one byte later, as a shifted bit alignment. The stimulus therefore sends a few extra external clock edges while the flag is high. It then reads and sends one clean byte, and compares that byte with the expected value. A partial frame cut short by dropping the enable is handled the same way. In generated-clock mode, the bench holds the flag high for many divider periods and counts `sckOut` falling edges to show that the clock stays parked.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shift;  // take one bit into the shift register
    logic load;   // copy assembled byte into the holding register
  } rxStrobe_t;
endpackage

// File: rtl/sio_rx_dpath.sv
module sio_rx_dpath
  import sio_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              extSck,
  input  rxStrobe_t         stb,
  output logic              extRise,
  output logic              extFall,
  output logic [DATA_W-1:0] rxData
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] dataSync;
  logic [SYNC_STAGES-1:0] sckSync;
  logic                   sckPrev;
  logic [DATA_W-1:0]      shiftReg;
  logic [DATA_W-1:0]      holdReg;
  logic [DATA_W-1:0]      nextWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataSync <= '0;
      sckSync  <= '0;
      sckPrev  <= 1'b0;
    end else begin
      dataSync <= {dataSync[LAST-1:0], serIn};
      sckSync  <= {sckSync[LAST-1:0], extSck};
      sckPrev  <= sckSync[LAST];
    end
  end

  assign extRise  = sckSync[LAST] & ~sckPrev;
  assign extFall  = ~sckSync[LAST] & sckPrev;
  assign nextWord = {dataSync[LAST], shiftReg[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      holdReg  <= '0;
    end else begin
      if (stb.shift) shiftReg <= nextWord;
      if (stb.load)  holdReg  <= nextWord;
    end
  end

  assign rxData = holdReg;

  // R5 / R6: holding register only moves on a load strobe
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(holdReg));
endmodule

// File: rtl/sio_rx_ctrl.sv
module sio_rx_ctrl
  import sio_rx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      clkSrcExt,
  input  logic      fallEdge,
  input  logic      readStb,
  input  logic      extRise,
  input  logic      extFall,
  output rxStrobe_t stb,
  output logic      sckOut,
  output logic      rxFull,
  output logic      rxIrq
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             genActive;
  logic             tick;
  logic             extEdge;
  logic             shiftNow;
  logic             lastBit;

  assign genActive = rxEnable & ~rxFull & ~clkSrcExt;
  assign tick      = genActive & (divCnt == DIV_END);
  assign extEdge   = fallEdge ? extFall : extRise;
  assign shiftNow  = rxEnable & ~rxFull & (clkSrcExt ? extEdge : (tick & ~sckOut));
  assign lastBit   = (bitCnt == LAST_BIT);

  always_comb begin
    stb.shift = shiftNow;
    stb.load  = shiftNow & lastBit;
  end

  // Clock generator: parks high whenever not allowed to run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      sckOut <= 1'b1;
    end else if (!genActive) begin
      divCnt <= '0;
      sckOut <= 1'b1;
    end else if (tick) begin
      divCnt <= '0;
      sckOut <= ~sckOut;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxFull <= 1'b0;
      rxIrq  <= 1'b0;
    end else begin
      if (!rxEnable)     bitCnt <= '0;
      else if (shiftNow) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      if (stb.load)      rxFull <= 1'b1;
      else if (readStb)  rxFull <= 1'b0;
      rxIrq <= stb.load;
    end
  end

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);
  p_irq_on_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> rxIrq);
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxFull && readStb |=> !rxFull);
  p_no_shift_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> !stb.shift);
  p_sck_parked_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> sckOut);
  p_cnt_cleared_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> bitCnt == '0);
endmodule

// File: rtl/sio_rx_gate.sv
module sio_rx_gate
  import sio_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              clkSrcExt,
  input  logic              fallEdge,
  input  logic              readStb,
  input  logic              serIn,
  input  logic              extSck,
  output logic              sckOut,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxIrq
);
  rxStrobe_t stb;
  logic      extRise;
  logic      extFall;

  sio_rx_ctrl #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .clkSrcExt(clkSrcExt),
    .fallEdge(fallEdge), .readStb(readStb), .extRise(extRise), .extFall(extFall),
    .stb(stb), .sckOut(sckOut), .rxFull(rxFull), .rxIrq(rxIrq)
  );

  sio_rx_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .serIn(serIn), .extSck(extSck), .stb(stb),
    .extRise(extRise), .extFall(extFall), .rxData(rxData)
  );
endmodule

// File: tb/sim_sio_rx_gate.sv
module sim_sio_rx_gate;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0, clkSrcExt = 1'b1, fallEdge = 1'b0, readStb = 1'b0;
  logic serIn = 1'b0, extSck = 1'b0;
  logic sckOut, rxFull, rxIrq;
  logic [7:0] rxData;

  int checks = 0, errors = 0;
  int irqCycles = 0, sckFalls = 0;
  logic genDrive = 1'b0;
  logic [7:0] genByte = 8'h00;
  logic [2:0] genIdx = 3'd0;

  always #4 clk = ~clk;

  sio_rx_gate #(.DATA_W(8), .HALF_DIV(HALF), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .clkSrcExt(clkSrcExt),
    .fallEdge(fallEdge), .readStb(readStb), .serIn(serIn), .extSck(extSck),
    .sckOut(sckOut), .rxData(rxData), .rxFull(rxFull), .rxIrq(rxIrq)
  );

  always @(posedge clk) if (rxIrq) irqCycles++;
  always @(negedge sckOut) begin
    sckFalls++;
    if (genDrive) begin
      serIn <= genByte[genIdx];
      genIdx <= genIdx + 3'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic extBit(input logic b, input logic fall);
    serIn = b;
    repeat (3) @(negedge clk);
    extSck = ~fall;
    repeat (4) @(negedge clk);
    extSck = fall;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendExt(input logic [7:0] v, input logic fall);
    for (int i = 0; i < 8; i++) extBit(v[i], fall);
  endtask

  task automatic doRead();
    @(negedge clk) readStb = 1'b1;
    @(negedge clk) readStb = 1'b0;
  endtask

  task automatic waitFull();
    for (int i = 0; i < 400 && !rxFull; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rxFull", rxFull, 0);
    chk("R1 rxIrq", rxIrq, 0);
    chk("R1 rxData", rxData, 8'h00);
    chk("R1 sckOut", sckOut, 1);
  endtask

  task automatic t_rise();
    int i0 = irqCycles;
    clkSrcExt = 1'b1; fallEdge = 1'b0; extSck = 1'b0; rxEnable = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 7; i++) extBit(8'hB1 >> i, 1'b0);
    chk("R4 no flag before bit 8", rxFull, 0);
    extBit(1'b1, 1'b0);
    chk("R2 rising LSB-first byte", rxData, 8'hB1);
    chk("R4 flag set", rxFull, 1);
    chk("R4 one irq cycle", irqCycles - i0, 1);
  endtask

  task automatic t_read();
    doRead();
    chk("R5 flag cleared", rxFull, 0);
    chk("R5 data kept", rxData, 8'hB1);
  endtask

  task automatic t_fall();
    int i0 = irqCycles;
    fallEdge = 1'b1; extSck = 1'b1;
    repeat (6) @(negedge clk);
    sendExt(8'h4E, 1'b1);
    chk("R3 falling-edge byte", rxData, 8'h4E);
    chk("R3 flag", rxFull, 1);
    chk("R4 irq once", irqCycles - i0, 1);
    doRead();
    fallEdge = 1'b0; extSck = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_ignore();
    sendExt(8'h12, 1'b0);
    for (int i = 0; i < 3; i++) extBit(1'b1, 1'b0);
    chk("R6 data held while full", rxData, 8'h12);
    chk("R6 flag held", rxFull, 1);
    doRead();
    sendExt(8'hC7, 1'b0);
    chk("R6 next byte aligned", rxData, 8'hC7);
    doRead();
  endtask

  task automatic t_gen();
    int n = 0;
    rxEnable = 1'b0;
    @(negedge clk);
    clkSrcExt = 1'b0; genByte = 8'h9D; genIdx = 3'd0; genDrive = 1'b1;
    @(negedge clk);
    chk("R7 idle high", sckOut, 1);
    rxEnable = 1'b1;
    @(negedge sckOut);
    @(negedge clk);
    while (!sckOut && n < 100) begin n++; @(negedge clk); end
    chk("R7 half period", n, HALF);
    waitFull();
    chk("R7 generated-clock byte", rxData, 8'h9D);
    chk("R7 flag", rxFull, 1);
  endtask

  task automatic t_stall();
    int f0 = sckFalls;
    repeat (60) @(negedge clk);
    chk("R8 no clock while full", sckFalls - f0, 0);
    chk("R8 parked high", sckOut, 1);
    genByte = 8'h69; genIdx = 3'd0;
    doRead();
    waitFull();
    chk("R8 resumes after read", rxData, 8'h69);
  endtask

  task automatic t_disable();
    rxEnable = 1'b0; genDrive = 1'b0;
    @(negedge clk);
    clkSrcExt = 1'b1; extSck = 1'b0;
    doRead();
    repeat (4) @(negedge clk);
    chk("R9 sckOut high when off", sckOut, 1);
    sendExt(8'hFF, 1'b0);
    chk("R9 no flag when disabled", rxFull, 0);
    chk("R9 data kept when disabled", rxData, 8'h69);
    rxEnable = 1'b1;
    for (int i = 0; i < 4; i++) extBit(1'b1, 1'b0);
    rxEnable = 1'b0;
    repeat (3) @(negedge clk);
    rxEnable = 1'b1;
    sendExt(8'h5A, 1'b0);
    chk("R9 restart from bit 0", rxData, 8'h5A);
    chk("R9 flag after restart", rxFull, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1-timeout actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_rise();
    t_read();
    t_fall();
    t_ignore();
    t_gen();
    t_stall();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule